// File: doc/BRIEF.md
# Page-mode DRAM sequencer

This block sits between a simple host request port and a DRAM array organised as a square of rows and columns of words. Each host address is cut into a row half (upper bits) and a column half (lower bits), and both halves travel, one after the other, over a single shared address bus qualified by an active-low row strobe and an active-low column strobe.

After a row has been opened, the row strobe is left asserted, so the array keeps the whole row in its internal row buffer. A later request to the same row is served by a column strobe alone. A request to a different row releases the row strobe, waits out a precharge interval, and then strobes the new row before the column. If the host sends nothing for a fixed number of cycles, the open row is closed. Read data comes back as a single-cycle response pulse. Write data and its output enable are driven only while the column strobe is low.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: `req_addr[2*AW-1:AW]` is the row and `req_addr[AW-1:0]` is the column. The row is on `dram_addr` in the cycle in which `dram_ras_n` falls, and the column is on `dram_addr` in every cycle in which `dram_cas_n` is 0.
- R3: With no row open, a request asserts `dram_ras_n` low in the cycle after acceptance, and `dram_cas_n` falls only after `dram_ras_n` has been low for T_RCD cycles (default 2). A read then returns `rsp_valid` on the 4th cycle after acceptance.
- R4: A request whose row equals the open row produces no edge on `dram_ras_n`. It asserts `dram_cas_n` in the next cycle, and a read returns `rsp_valid` on the 2nd cycle after acceptance.
- R5: A request to a different row raises `dram_ras_n` for exactly T_RP cycles (default 2) before the new row is strobed. A read then returns on the 6th cycle after acceptance. `dram_ras_n` never falls after fewer than T_RP high cycles.
- R6: Every assertion of `dram_cas_n` lasts exactly T_CAS cycles (default 1).
- R7: For a write, `dram_we_n` is 0, `dram_dq_oe` is 1 and `dram_dq_out` carries the write data while `dram_cas_n` is 0. For reads, and outside the column strobe, `dram_we_n` is 1 and `dram_dq_oe` is 0.
- R8: For a read, `rsp_valid` is 1 for exactly one cycle, the cycle after the column strobe ends, with `rsp_rdata` equal to the array word at that row and column. Writes produce no response.
- R9: `req_ready` is 1 only when no request is in progress, and it is 0 from the cycle after acceptance until the request completes.
- R10: After IDLE_TO idle cycles (default 16) with a row open, `dram_ras_n` returns to 1. The next request then takes the closed-row path of R3.
- R11: `dram_cas_n` is never 0 while `dram_ras_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*AW | Word address, row in upper half |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DW | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_out | output | DW | Data toward the array |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DW | Data from the array |

## Verification
The assertions assume that T_RP, T_RCD and T_CAS are at least 1. They also assume that the array answers a read combinationally while the column strobe is low, so the word is present when the strobe ends. The bench's array model works in exactly that way. The stimulus changes `req_valid` only on falling edges, keeps it high until acceptance, and issues a new request only after the previous one has finished. This avoids any overlap of requests, which the interface would not admit anyway.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 1,
  parameter int IDLE_TO = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic [AW-1:0] dram_addr,
  output logic [DW-1:0] dram_dq_out,
  output logic          dram_dq_oe,
  input  logic [DW-1:0] dram_dq_in
);
  localparam int TW = 8;
  localparam int IW = $clog2(IDLE_TO + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_CAS} state_t;

  state_t        state;
  logic [TW-1:0] cnt;
  logic [IW-1:0] idle_cnt;
  logic          row_open, pend, cur_we;
  logic [AW-1:0] open_row, cur_col;
  logic [DW-1:0] cur_wd;

  wire [AW-1:0] req_row = req_addr[2*AW-1:AW];
  wire [AW-1:0] req_col = req_addr[AW-1:0];
  wire          accept  = req_valid && req_ready;
  wire          in_cas  = (state == S_CAS);

  assign req_ready   = (state == S_IDLE);
  assign dram_ras_n  = ~row_open;
  assign dram_cas_n  = ~in_cas;
  assign dram_we_n   = ~(in_cas && cur_we);
  assign dram_dq_oe  = in_cas && cur_we;
  assign dram_dq_out = cur_wd;
  assign dram_addr   = in_cas ? cur_col : open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      idle_cnt  <= '0;
      row_open  <= 1'b0;
      pend      <= 1'b0;
      cur_we    <= 1'b0;
      open_row  <= '0;
      cur_col   <= '0;
      cur_wd    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            open_row <= req_row;
            cur_col  <= req_col;
            cur_we   <= req_we;
            cur_wd   <= req_wdata;
            idle_cnt <= '0;
            if (row_open && req_row == open_row) begin
              state <= S_CAS;
              cnt   <= TW'(T_CAS - 1);
            end else if (row_open) begin
              row_open <= 1'b0;
              pend     <= 1'b1;
              state    <= S_PRE;
              cnt      <= TW'(T_RP - 1);
            end else begin
              row_open <= 1'b1;
              state    <= S_ACT;
              cnt      <= TW'(T_RCD - 1);
            end
          end else if (row_open) begin
            if (idle_cnt == IW'(IDLE_TO - 1)) begin
              row_open <= 1'b0;
              pend     <= 1'b0;
              state    <= S_PRE;
              cnt      <= TW'(T_RP - 1);
              idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
        end
        S_PRE: begin
          if (cnt == '0) begin
            if (pend) begin
              row_open <= 1'b1;
              state    <= S_ACT;
              cnt      <= TW'(T_RCD - 1);
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ACT: begin
          if (cnt == '0) begin
            state <= S_CAS;
            cnt   <= TW'(T_CAS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            state <= S_IDLE;
            if (!cur_we) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic req_ready,
  input logic rsp_valid
);
  logic [7:0] hi_run, lo_run, cas_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run  <= 8'hFF;
      lo_run  <= '0;
      cas_run <= '0;
    end else begin
      hi_run  <= ras_n ? ((hi_run == 8'hFF) ? hi_run : hi_run + 1'b1) : 8'd0;
      lo_run  <= !ras_n ? ((lo_run == 8'hFF) ? lo_run : lo_run + 1'b1) : 8'd0;
      cas_run <= !cas_n ? ((cas_run == 8'hFF) ? cas_run : cas_run + 1'b1) : 8'd0;
    end
  end

  a_r11_cas_needs_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  a_r7_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n);
  a_r7_oe_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);
  a_r5_precharge_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_run >= 8'(T_RP));
  a_r3_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> lo_run >= 8'(T_RCD));
  a_r6_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> cas_run == 8'(T_CAS));
  a_r8_rsp_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(cas_n));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_busy_in_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !req_ready);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .dq_oe(dram_dq_oe), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
  localparam int AW = 4, DW = 8, T_RP = 2, T_RCD = 2, T_CAS = 1, IDLE_TO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_out, dq_in;
  logic [AW-1:0] daddr;

  always #2 clk = ~clk;

  fpm_dram_ctrl #(.AW(AW), .DW(DW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .IDLE_TO(IDLE_TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(daddr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  // behavioural array plus protocol monitor, sampled on falling edges
  logic [DW-1:0] arr [0:(1<<(2*AW))-1];
  logic [AW-1:0] lat_row = '0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int hi_run = 1000, lo_run = 0, cas_run = 0;
  int ras_falls = 0, cas_falls = 0, rsp_cnt = 0;
  int proto_err = 0, rp_err = 0, rcd_err = 0, wid_err = 0, oe_err = 0;
  int tests = 0, fails = 0;

  assign dq_in = (!cas_n && we_n) ? arr[{lat_row, daddr}] : '0;

  initial for (int i = 0; i < (1<<(2*AW)); i++) arr[i] = '0;

  always @(negedge clk) if (rst_n) begin
    if (prev_ras && !ras_n) begin
      ras_falls++; lat_row = daddr;
      if (hi_run < T_RP) rp_err++;
    end
    if (prev_cas && !cas_n) begin
      cas_falls++;
      if (lo_run < T_RCD) rcd_err++;
    end
    if (!prev_cas && cas_n && cas_run != T_CAS) wid_err++;
    if (!cas_n && ras_n) proto_err++;
    if ((dq_oe != !we_n) || (!we_n && cas_n)) oe_err++;
    if (!cas_n && !we_n) arr[{lat_row, daddr}] = dq_out;
    if (rsp_valid) rsp_cnt++;
    hi_run  = ras_n ? hi_run + 1 : 0;
    lo_run  = !ras_n ? lo_run + 1 : 0;
    cas_run = !cas_n ? cas_run + 1 : 0;
    prev_ras = ras_n; prev_cas = cas_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one request; returns cycles to response (reads) or to ready (writes)
  task automatic issue(input bit we, input logic [2*AW-1:0] a, input logic [DW-1:0] d,
                       output int lat, output logic [DW-1:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9 ready after accept", req_ready, 0);
    lat = 1; rd = '0;
    if (!we) begin
      while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
    end else begin
      while (!req_ready && lat < 40) begin @(negedge clk); lat++; end
    end
  endtask

  task automatic t_reset();
    check(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
    check(!dq_oe && !rsp_valid, "R1 outputs quiet", {dq_oe, rsp_valid}, 0);
    check(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_write_closed();
    int l; logic [DW-1:0] r; int rf = ras_falls, cf = cas_falls, rc = rsp_cnt;
    issue(1'b1, 8'h35, 8'hA1, l, r);
    check(ras_falls - rf == 1, "R3 one row strobe", ras_falls - rf, 1);
    check(cas_falls - cf == 1, "R3 one column strobe", cas_falls - cf, 1);
    check(lat_row == 4'h3, "R2 row half", lat_row, 3);
    check(arr[8'h35] == 8'hA1, "R7 write data landed", arr[8'h35], 8'hA1);
    check(rsp_cnt == rc, "R8 no write response", rsp_cnt - rc, 0);
  endtask

  task automatic t_read_hit();
    int l; logic [DW-1:0] r; int rf = ras_falls, rc;
    issue(1'b1, 8'h3C, 8'h5E, l, r);
    check(ras_falls == rf, "R4 hit write no RAS edge", ras_falls - rf, 0);
    rc = rsp_cnt;
    issue(1'b0, 8'h35, 8'h00, l, r);
    check(l == 2, "R4 hit read latency", l, 2);
    check(r == 8'hA1, "R8 hit read data", r, 8'hA1);
    check(ras_falls == rf, "R4 hit read no RAS edge", ras_falls - rf, 0);
    @(negedge clk);
    check(!rsp_valid && rsp_cnt - rc == 1, "R8 one-cycle pulse", rsp_cnt - rc, 1);
  endtask

  task automatic t_read_miss();
    int l; logic [DW-1:0] r; int rf = ras_falls;
    issue(1'b0, 8'h70, 8'h00, l, r);
    check(l == T_RP + T_RCD + T_CAS + 1, "R5 miss latency", l, T_RP + T_RCD + T_CAS + 1);
    check(r == 8'h00, "R8 unwritten word", r, 0);
    check(lat_row == 4'h7, "R2 new row latched", lat_row, 7);
    check(ras_falls - rf == 1, "R5 one new row strobe", ras_falls - rf, 1);
    issue(1'b0, 8'h3C, 8'h00, l, r);
    check(l == 6, "R5 miss back latency", l, 6);
    check(r == 8'h5E, "R2 column half data", r, 8'h5E);
  endtask

  task automatic t_row_sweep();
    int l; logic [DW-1:0] r;
    for (int c = 0; c < 16; c++) issue(1'b1, {4'h9, 4'(c)}, 8'(8'h40 + c * 3), l, r);
    for (int c = 15; c >= 0; c--) begin
      issue(1'b0, {4'h9, 4'(c)}, 8'h00, l, r);
      check(r == 8'(8'h40 + c * 3), "R8 sweep data", r, 8'h40 + c * 3);
      check(l == 2, "R4 sweep hit", l, 2);
    end
  endtask

  task automatic t_timeout();
    int l; logic [DW-1:0] r;
    issue(1'b0, 8'h95, 8'h00, l, r);
    repeat (14) @(negedge clk);
    check(ras_n == 1'b0, "R10 row still open", ras_n, 0);
    repeat (3) @(negedge clk);
    check(ras_n == 1'b1, "R10 row closed", ras_n, 1);
    repeat (4) @(negedge clk);
    issue(1'b0, 8'h35, 8'h00, l, r);
    check(l == T_RCD + T_CAS + 1, "R10 closed-path latency", l, T_RCD + T_CAS + 1);
    check(r == 8'hA1, "R3 closed-path data", r, 8'hA1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && req_ready, "R1 during reset", {ras_n, cas_n}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_closed();
    t_read_hit();
    t_read_miss();
    t_row_sweep();
    t_timeout();
    repeat (4) @(negedge clk);
    check(proto_err == 0, "R11 CAS only under RAS", proto_err, 0);
    check(rp_err == 0, "R5 precharge width", rp_err, 0);
    check(rcd_err == 0, "R3 RAS-to-CAS gap", rcd_err, 0);
    check(wid_err == 0, "R6 CAS width", wid_err, 0);
    check(oe_err == 0, "R7 enable window", oe_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule